// File: doc/BRIEF.md
# JTAG Debug-Port Scan Chain

This block is the test-clock front end of a debug port. A 16-state TAP controller runs on `tck` and `tms`. An asynchronous active-low `trst_n` returns it to Test-Logic-Reset. A 4-bit instruction register chooses which serial chain sits between `tdi` and `tdo`. The choices are a 1-bit bypass stage, a 32-bit identification chain, an abort chain, and two 35-bit access chains. One access chain targets debug-port registers and the other targets access-port registers.

Shifting an access chain loads a request: write data, two register-address bits and a read flag. When the controller passes Update-DR, the block issues that request on its internal side for one `tck` cycle. In Capture-DR the same chain loads the read data that the internal side presents, together with a 3-bit acknowledge. The acknowledge reads OK while the internal side is idle and WAIT while `rsp_wait` shows an access still pending. While WAIT holds, no new request is issued.

Top module: `jtag_dbg_scan`

## Requirements
- R1: A low `trst_n` puts the controller in Test-Logic-Reset at once, without a `tck` edge. It forces `tdo` to 0 and reloads the instruction register with the identification opcode 1110.
- R2: Five consecutive `tck` rising edges with `tms` = 1 reach Test-Logic-Reset from any state, and that state also restores opcode 1110.
- R3: In Capture-IR the instruction chain loads 0001. A Shift-IR sequence shifts it out on `tdo`, least significant bit first.
- R4: Opcodes 0000–0111, 1001, 1100, 1101 and 1111 select a 1-bit chain. That chain captures 0 and delays `tdi` by one shift.
- R5: Opcode 1110 selects a 32-bit chain that captures the parameter `IDCODE_VAL`, whose bit 0 must be 1.
- R6: Opcode 1010 (debug-port chain, `req_ap` = 0) and opcode 1011 (access-port chain, `req_ap` = 1) are 35 bits long. Shifted-in bit 0 is `req_rnw` (1 = read), bits 2:1 are `req_addr`, and bits 34:3 are `req_wdata`. On Update-DR with `rsp_wait` low, `req_valid` is high for exactly one `tck` cycle.
- R7: On Capture-DR of an access chain, bits 34:3 take `rsp_rdata` and bits 2:0 take the acknowledge. The acknowledge is 010 (OK) when `rsp_wait` is low.
- R8: While `rsp_wait` is high, Capture-DR of an access chain loads acknowledge 001 (WAIT), and Update-DR issues no request.
- R9: Opcode 1000 selects a 35-bit abort chain. On Update-DR a 1 in bit 0 raises `abort_pulse` for exactly one cycle, and a 0 raises nothing. Bits 34:1 have no effect.
- R10: `req_valid` and `abort_pulse` stay low in Run-Test/Idle. They also stay low after Update-DR of a bypass or identification chain.
- R11: `tdo` changes on the falling edge of `tck` and is 0 outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| rsp_rdata | input | 32 | Read data from the internal side |
| rsp_wait | input | 1 | Internal side still busy with the last access |
| req_valid | output | 1 | One-cycle access request strobe |
| req_ap | output | 1 | 1 = access-port target, 0 = debug-port target |
| req_addr | output | 2 | Register address bits A[3:2] |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_wdata | output | 32 | Write data |
| abort_pulse | output | 1 | One-cycle access-port abort request |

## Verification
The bench targets several corner cases, each with a known failure signature.
- The two access chains have different layouts in and out. A mix-up shows as a swapped address or read flag on the request, or as acknowledge bits landing in the read data.
- WAIT is tested with random read data and random `rsp_wait`. A design that ignores it would issue a second request or report OK while an access is still pending.
- The abort chain is scanned with random upper bits and bit 0 cleared. A decoder that looks at the wrong bit would pulse when it should not.
- Reset is tested both asynchronously in the middle of a scan and through five TMS-high clocks. A controller that loses either path leaves the instruction register on an access opcode instead of the identification chain.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;

   localparam int IR_W = 4;

   typedef enum logic [3:0] {
      TAP_RESET   = 4'h0,
      TAP_IDLE    = 4'h1,
      TAP_SEL_DR  = 4'h2,
      TAP_CAP_DR  = 4'h3,
      TAP_SH_DR   = 4'h4,
      TAP_EX1_DR  = 4'h5,
      TAP_PAU_DR  = 4'h6,
      TAP_EX2_DR  = 4'h7,
      TAP_UPD_DR  = 4'h8,
      TAP_SEL_IR  = 4'h9,
      TAP_CAP_IR  = 4'hA,
      TAP_SH_IR   = 4'hB,
      TAP_EX1_IR  = 4'hC,
      TAP_PAU_IR  = 4'hD,
      TAP_EX2_IR  = 4'hE,
      TAP_UPD_IR  = 4'hF
   } tap_state_t;

   localparam logic [IR_W-1:0] OP_ABORT  = 4'b1000;
   localparam logic [IR_W-1:0] OP_DPACC  = 4'b1010;
   localparam logic [IR_W-1:0] OP_APACC  = 4'b1011;
   localparam logic [IR_W-1:0] OP_IDCODE = 4'b1110;
   localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

   localparam logic [2:0] ACK_OK   = 3'b010;
   localparam logic [2:0] ACK_WAIT = 3'b001;

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
   import jtag_dbg_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   tap_state_t nxt;

   always_comb begin
      unique case (state)
         TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
         TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
         TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
         TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
         TAP_SH_DR:  nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
         TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
         TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
         TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
         TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
         TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
         TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
         TAP_SH_IR:  nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
         TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
         TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
         TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
         default:    nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TAP_RESET;
      else         state <= nxt;
   end

endmodule

// File: rtl/jtag_ir_reg.sv
module jtag_ir_reg
   import jtag_dbg_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_state_t      state,
   output logic [IR_W-1:0] ir,
   output logic            ir_so
);

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= IR_CAPTURE;
         ir    <= OP_IDCODE;
      end else begin
         case (state)
            TAP_RESET:  ir    <= OP_IDCODE;
            TAP_CAP_IR: ir_sh <= IR_CAPTURE;
            TAP_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            TAP_UPD_IR: ir    <= ir_sh;
            default: ;
         endcase
      end
   end

   assign ir_so = ir_sh[0];

endmodule

// File: rtl/jtag_dr_chain.sv
module jtag_dr_chain
   import jtag_dbg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int ACK_W  = 3,
   parameter int ID_W   = 32,
   parameter logic [ID_W-1:0] IDCODE_VAL = 32'h5A7E_3C4B
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tdi,
   input  tap_state_t        state,
   input  logic [IR_W-1:0]   ir,
   input  logic [DATA_W-1:0] rsp_rdata,
   input  logic              rsp_wait,
   output logic              dr_so,
   output logic              req_valid,
   output logic              req_ap,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_rnw,
   output logic [DATA_W-1:0] req_wdata,
   output logic              abort_pulse
);

   localparam int ACC_W = DATA_W + ADDR_W + 1;
   localparam int MAXW  = ACC_W;

   logic [MAXW-1:0] sh, nxt;
   logic [MAXW:0]   ext;
   int              len;
   logic            is_acc;

   assign is_acc = (ir == OP_DPACC) || (ir == OP_APACC);

   always_comb begin
      case (ir)
         OP_ABORT, OP_DPACC, OP_APACC: len = ACC_W;
         OP_IDCODE:                    len = ID_W;
         default:                      len = 1;
      endcase
   end

   always_comb begin
      ext = {1'b0, sh};
      for (int i = 0; i < MAXW; i++) begin
         if (i == len - 1)     nxt[i] = tdi;
         else if (i < len - 1) nxt[i] = ext[i+1];
         else                  nxt[i] = sh[i];
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh          <= '0;
         req_valid   <= 1'b0;
         req_ap      <= 1'b0;
         req_addr    <= '0;
         req_rnw     <= 1'b0;
         req_wdata   <= '0;
         abort_pulse <= 1'b0;
      end else begin
         req_valid   <= 1'b0;
         abort_pulse <= 1'b0;
         case (state)
            TAP_CAP_DR: begin
               if (is_acc)
                  sh <= {rsp_rdata, (rsp_wait ? ACK_WAIT : ACK_OK)};
               else if (ir == OP_IDCODE)
                  sh <= MAXW'(IDCODE_VAL);
               else
                  sh <= '0;
            end
            TAP_SH_DR: sh <= nxt;
            TAP_UPD_DR: begin
               if (is_acc && !rsp_wait) begin
                  req_valid <= 1'b1;
                  req_ap    <= (ir == OP_APACC);
                  req_rnw   <= sh[0];
                  req_addr  <= sh[ADDR_W:1];
                  req_wdata <= sh[ACC_W-1:ADDR_W+1];
               end
               if (ir == OP_ABORT) abort_pulse <= sh[0];
            end
            default: ;
         endcase
      end
   end

   assign dr_so = sh[0];

endmodule

// File: rtl/jtag_dbg_scan.sv
module jtag_dbg_scan
   import jtag_dbg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int ACK_W  = 3,
   parameter int ID_W   = 32,
   parameter logic [ID_W-1:0] IDCODE_VAL = 32'h5A7E_3C4B
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   input  logic [DATA_W-1:0] rsp_rdata,
   input  logic              rsp_wait,
   output logic              req_valid,
   output logic              req_ap,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_rnw,
   output logic [DATA_W-1:0] req_wdata,
   output logic              abort_pulse
);

   generate
      if (DATA_W + ADDR_W + 1 != DATA_W + ACK_W) begin : g_bad_layout
         $error("access chain in/out layouts must be the same length");
      end
      if (ID_W > DATA_W + ADDR_W + 1) begin : g_bad_id
         $error("identification chain longer than access chain");
      end
      if (IDCODE_VAL[0] != 1'b1) begin : g_bad_idval
         $error("identification value must have bit 0 set");
      end
   endgenerate

   tap_state_t      tap_state;
   logic [IR_W-1:0] ir_cur;
   logic            ir_so, dr_so;

   jtag_tap_ctrl u_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state)
   );

   jtag_ir_reg u_ir (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state),
      .ir(ir_cur), .ir_so(ir_so)
   );

   jtag_dr_chain #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACK_W(ACK_W),
      .ID_W(ID_W), .IDCODE_VAL(IDCODE_VAL)
   ) u_dr (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state), .ir(ir_cur),
      .rsp_rdata(rsp_rdata), .rsp_wait(rsp_wait), .dr_so(dr_so),
      .req_valid(req_valid), .req_ap(req_ap), .req_addr(req_addr),
      .req_rnw(req_rnw), .req_wdata(req_wdata), .abort_pulse(abort_pulse)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                    tdo <= 1'b0;
      else if (tap_state == TAP_SH_IR) tdo <= ir_so;
      else if (tap_state == TAP_SH_DR) tdo <= dr_so;
      else                            tdo <= 1'b0;
   end

endmodule

// File: rtl/jtag_dbg_scan_chk.sv
module jtag_dbg_scan_chk
   import jtag_dbg_pkg::*;
(
   input logic            tck,
   input logic            trst_n,
   input tap_state_t      state,
   input logic [IR_W-1:0] ir,
   input logic            tdo,
   input logic            req_valid,
   input logic            abort_pulse,
   input logic            rsp_wait
);

   AST_REQ_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |=> !req_valid); // R6

   AST_REQ_AFTER_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |-> $past(state) == TAP_UPD_DR); // R6

   AST_NO_REQ_ON_WAIT: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_UPD_DR && rsp_wait) |=> !req_valid); // R8

   AST_ABORT_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
      abort_pulse |=> !abort_pulse); // R9

   AST_IDLE_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TAP_IDLE && $past(state) == TAP_IDLE) |-> (!req_valid && !abort_pulse)); // R10

   AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
      state == TAP_RESET |=> ir == OP_IDCODE); // R2

   AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
      (state != TAP_SH_DR && state != TAP_SH_IR) |-> !tdo); // R11

endmodule

bind jtag_dbg_scan jtag_dbg_scan_chk u_chk (
   .tck(tck), .trst_n(trst_n), .state(tap_state), .ir(ir_cur), .tdo(tdo),
   .req_valid(req_valid), .abort_pulse(abort_pulse), .rsp_wait(rsp_wait)
);

// File: tb/test_jtag_dbg_scan.sv
module test_jtag_dbg_scan;

   localparam logic [31:0] ID = 32'h5A7E_3C4B;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo;
   logic [31:0] rsp_rdata = '0;
   logic        rsp_wait = 1'b0;
   logic        req_valid, req_ap, req_rnw, abort_pulse;
   logic [1:0]  req_addr;
   logic [31:0] req_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 tck = ~tck;

   jtag_dbg_scan #(.IDCODE_VAL(ID)) i_jtag_dbg_scan (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .rsp_rdata(rsp_rdata), .rsp_wait(rsp_wait), .req_valid(req_valid),
      .req_ap(req_ap), .req_addr(req_addr), .req_rnw(req_rnw),
      .req_wdata(req_wdata), .abort_pulse(abort_pulse)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck); @(negedge tck); #1;
   endtask

   task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 4; i++) begin
         cap[i] = tdo;
         tick(i == 3, op[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         tick(i == n - 1, din[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   function automatic logic [34:0] exp_cap(input logic [31:0] rd, input logic w);
      return {rd, (w ? 3'b001 : 3'b010)};
   endfunction

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0]  cap;
      logic [63:0] dout;
      logic [63:0] din;
      void'($urandom(32'd1234));

      repeat (3) @(posedge tck);
      @(negedge tck); #1;
      trst_n = 1'b1;
      tick(0, 0);
      chk("R1 reset tdo", {63'd0, tdo}, 64'd0);
      chk("R10 reset req", {62'd0, req_valid, abort_pulse}, 64'd0);

      // R5 + R1: default instruction is identification
      scan_dr(32, 64'h0, dout);
      chk("R5 idcode", dout, {32'd0, ID});
      chk("R5 idcode bit0", {63'd0, dout[0]}, 64'd1);

      // R3: capture pattern of the instruction chain
      scan_ir(4'b1010, cap);
      chk("R3 ir capture", {60'd0, cap}, 64'd1);

      // R2: five TMS-high clocks restore identification
      repeat (5) tick(1, 0);
      tick(0, 0);
      scan_dr(32, 64'h0, dout);
      chk("R2 tms reset", dout, {32'd0, ID});

      // R4: bypass opcodes, random subset
      for (int k = 0; k < 6; k++) begin
         logic [3:0] op;
         case ($urandom_range(0, 4))
            0: op = 4'($urandom_range(0, 7));
            1: op = 4'b1001;
            2: op = 4'b1100;
            3: op = 4'b1101;
            default: op = 4'b1111;
         endcase
         scan_ir(op, cap);
         din = {56'd0, 8'($urandom)};
         scan_dr(9, din, dout);
         chk($sformatf("R4 bypass op=%b", op), dout, {din[62:0], 1'b0});
         chk("R10 bypass quiet", {62'd0, req_valid, abort_pulse}, 64'd0);
      end

      // R6 R7 R8: random access traffic
      for (int k = 0; k < 24; k++) begin
         logic [3:0] op;
         logic [34:0] req;
         op = ($urandom_range(0, 1) != 0) ? 4'b1011 : 4'b1010;
         rsp_rdata = $urandom;
         rsp_wait = (k == 3) ? 1'b1 : ($urandom_range(0, 3) == 0);
         req = {32'($urandom), 3'($urandom)};
         scan_ir(op, cap);
         scan_dr(35, {29'd0, req}, dout);
         if (rsp_wait)
            chk("R8 wait ack", dout, {29'd0, exp_cap(rsp_rdata, 1'b1)});
         else
            chk("R7 capture", dout, {29'd0, exp_cap(rsp_rdata, 1'b0)});
         chk(rsp_wait ? "R8 no request" : "R6 request", {63'd0, req_valid}, {63'd0, !rsp_wait});
         if (!rsp_wait) begin
            chk("R6 fields",
                {28'd0, req_ap, req_addr, req_rnw, req_wdata},
                {28'd0, (op == 4'b1011), req[2:1], req[0], req[34:3]});
            tick(0, 0);
            chk("R6 one cycle", {63'd0, req_valid}, 64'd0);
         end
      end
      rsp_wait = 1'b0;

      // R9: abort chain
      scan_ir(4'b1000, cap);
      scan_dr(35, {29'd0, 34'h0, 1'b1}, dout);
      chk("R9 abort pulse", {63'd0, abort_pulse}, 64'd1);
      chk("R9 abort no req", {63'd0, req_valid}, 64'd0);
      tick(0, 0);
      chk("R9 abort one cycle", {63'd0, abort_pulse}, 64'd0);
      for (int k = 0; k < 3; k++) begin
         din = {29'd0, 32'($urandom), 2'($urandom), 1'b1, 1'b0};
         scan_dr(35, din, dout);
         chk("R9 upper bits ignored", {63'd0, abort_pulse}, 64'd0);
      end

      // R10: idle holds nothing
      repeat (4) tick(0, 0);
      chk("R10 idle quiet", {62'd0, req_valid, abort_pulse}, 64'd0);

      // R1: asynchronous reset in the middle of a scan
      scan_ir(4'b1010, cap);
      tick(1, 0); tick(0, 0); tick(0, 0);
      tick(0, 1);
      #3 trst_n = 1'b0;
      #1;
      chk("R1 async tdo", {63'd0, tdo}, 64'd0);
      #2 trst_n = 1'b1;
      @(negedge tck); #1;
      tick(0, 0);
      scan_dr(32, 64'h0, dout);
      chk("R1 async idcode", dout, {32'd0, ID});
      chk("R11 tdo idle", {63'd0, tdo}, 64'd0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule